// File: doc/BRIEF.md
# Two-Wire Serial Bus Host Controller

This block is the only clock source on a two-wire serial bus. It runs one complete transaction for each start request on its command inputs. It generates the START condition, the seven-bit target address with its direction bit, one data byte, the acknowledge slot after each byte and the closing STOP condition. In a combined request it sends the address for writing, then the write byte, then a repeated START, then the same address for reading, and it reads one byte back. The clock line is a plain output. The data line is an active-low pull-enable together with a separate input that carries the resolved bus level. The controller never drives the data line high.

The serial clock is derived from the system clock. Each bit period is split into four equal quarters, and a level input selects standard rate (100 kHz) or fast rate (400 kHz). When the target does not acknowledge its address, a configuration input selects one of two responses. The controller either closes with STOP, or it issues a repeated START and sends the address again. Retries are limited by a parameter. The ack-error flag latches any acknowledge fault and clears when the next transaction is accepted.

Top module: `twi_host`

## Requirements
- R1: After reset, and whenever `busy` is low, `scl_o` is 1 and `sda_oe` is 0, so both lines are released.
- R2: While SCL stays high, SDA changes only for START (SDA falls) and STOP (SDA rises). Every other SDA change happens while SCL is low.
- R3: After START, the address byte is sent most-significant bit first as the 7 address bits followed by a direction bit (0 = write, 1 = read). A target samples each bit on the rising edge of SCL.
- R4: After each address or data byte, the controller releases SDA for a ninth SCL pulse. A low level sampled there is ACK and a high level is NACK.
- R5: A write request sends `cmd_wdata` most-significant bit first after the address is acknowledged, then issues STOP. It then raises `done` for exactly one clock cycle and drops `busy` in that same cycle.
- R6: A read request shifts 8 bits from the bus, most-significant bit first, into `rd_data`. It releases SDA in that byte's acknowledge slot (NACK, because it is the last byte) and then issues STOP.
- R7: A combined request (`cmd_combo` = 1) sends address+write, then the write byte, then a repeated START, then address+read, then the read byte, then STOP.
- R8: If the address is not acknowledged and `cmd_nack_retry` = 0, the controller issues STOP without any data byte and sets `ack_err`.
- R9: If the address is not acknowledged and `cmd_nack_retry` = 1, the controller issues a repeated START and resends the address, for at most RETRIES extra attempts, and then issues STOP.
- R10: `ack_err` latches any NACK on an address or a write byte. It is 0 from the clock edge that accepts the next `cmd_go`.
- R11: The SCL period is 4 × floor(SYS_CLK_HZ / (4 × rate)) system clocks, with rate = STD_HZ when `fast_mode` = 0 and rate = FAST_HZ when `fast_mode` = 1. SCL changes only on a quarter boundary.
- R12: If a write byte is not acknowledged, the controller issues STOP without a repeated START and sets `ack_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Starts a transaction when idle |
| cmd_addr | input | 7 | Target address |
| cmd_rd | input | 1 | Direction: 1 = read, 0 = write (ignored when combined) |
| cmd_wdata | input | 8 | Byte to write |
| cmd_combo | input | 1 | Write then repeated-START read |
| cmd_nack_retry | input | 1 | On address NACK: 1 = repeated START and retry, 0 = STOP |
| fast_mode | input | 1 | 1 = fast rate, 0 = standard rate |
| sda_i | input | 1 | Resolved SDA level |
| scl_o | output | 1 | Serial clock |
| sda_oe | output | 1 | 1 pulls SDA low |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | One-cycle end-of-transaction pulse |
| busy | output | 1 | Transaction in progress |
| ack_err | output | 1 | Latched acknowledge fault |

## Verification
The hardest situation to reach is a sequence of repeated STARTs inside one transaction. This happens in the bounded address retry, where the retry limit decides between a further START and the final STOP, and in the combined transfer, where the direction bit flips after the restart. The bench includes a target model that reacts to the bus. Its acknowledge of the address and its acknowledge of the write byte can each be switched off, so it can refuse every attempt or accept the exchange. A scoreboard holds the expected order of START, byte, acknowledge and STOP events, and the model checks each event against it as the event appears on the lines.

// File: rtl/twi_pkg.sv
package twi_pkg;

  localparam int TWI_BYTE_W = 8;
  localparam int TWI_ADDR_W = 7;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_BIT, ST_STOP} twi_state_e;
  typedef enum logic [1:0] {SEG_ADDR, SEG_WDATA, SEG_RDATA} twi_seg_e;

  // System clocks in one quarter of an SCL period, at least one.
  function automatic int unsigned twi_quarter_cycles(int unsigned clk_hz, int unsigned scl_hz);
    int unsigned q;
    q = clk_hz / (4 * scl_hz);
    return (q == 0) ? 1 : q;
  endfunction

  // Byte placed on the bus after a START: address then direction.
  function automatic logic [TWI_BYTE_W-1:0] twi_addr_byte(logic [TWI_ADDR_W-1:0] a, logic rd);
    return {a, rd};
  endfunction

endpackage

// File: rtl/twi_tick_gen.sv
module twi_tick_gen #(
  parameter int unsigned STD_Q  = 250,
  parameter int unsigned FAST_Q = 62
)(
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic restart,
  output logic tick
);
  localparam int unsigned MAXQ = (STD_Q > FAST_Q) ? STD_Q : FAST_Q;
  localparam int CW = (MAXQ > 1) ? $clog2(MAXQ) : 1;
  localparam logic [CW-1:0] STD_LIM  = CW'(STD_Q - 1);
  localparam logic [CW-1:0] FAST_LIM = CW'(FAST_Q - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  assign lim  = fast ? FAST_LIM : STD_LIM;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/twi_shifter.sv
module twi_shifter #(
  parameter int W = 8
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] par_in,
  input  logic         shift,
  input  logic         ser_in,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= par_in;
    else if (shift) q <= {q[W-2:0], ser_in};
  end
endmodule

// File: rtl/twi_host.sv
module twi_host
  import twi_pkg::*;
#(
  parameter int unsigned SYS_CLK_HZ = 100_000_000,
  parameter int unsigned STD_HZ     = 100_000,
  parameter int unsigned FAST_HZ    = 400_000,
  parameter int unsigned RETRIES    = 3
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_go,
  input  logic [TWI_ADDR_W-1:0] cmd_addr,
  input  logic                  cmd_rd,
  input  logic [TWI_BYTE_W-1:0] cmd_wdata,
  input  logic                  cmd_combo,
  input  logic                  cmd_nack_retry,
  input  logic                  fast_mode,
  input  logic                  sda_i,
  output logic                  scl_o,
  output logic                  sda_oe,
  output logic [TWI_BYTE_W-1:0] rd_data,
  output logic                  done,
  output logic                  busy,
  output logic                  ack_err
);
  localparam int unsigned STD_Q  = twi_quarter_cycles(SYS_CLK_HZ, STD_HZ);
  localparam int unsigned FAST_Q = twi_quarter_cycles(SYS_CLK_HZ, FAST_HZ);
  localparam int RCW = (RETRIES > 0) ? $clog2(RETRIES + 1) : 1;
  localparam logic [RCW-1:0] RETRY_MAX = RCW'(RETRIES);
  localparam logic [3:0] ACK_SLOT = 4'(TWI_BYTE_W);

  twi_state_e            st;
  twi_seg_e              seg;
  logic [1:0]            qtr;
  logic [3:0]            bitc;
  logic                  rd_phase, combo_q, retry_q, nack_q;
  logic                  scl_q, low_q, busy_q, done_q, err_q;
  logic [TWI_ADDR_W-1:0] addr_q;
  logic [TWI_BYTE_W-1:0] wdata_q, rdata_q, sh_q, sh_val;
  logic [RCW-1:0]        tries_q;
  logic                  tick, start_req, sh_load, sh_shift;

  // Named internal events for the checker.
  logic ev_tick, ev_in_start, ev_in_stop;
  assign ev_tick     = tick;
  assign ev_in_start = (st == ST_START);
  assign ev_in_stop  = (st == ST_STOP);

  assign start_req = (st == ST_IDLE) && cmd_go;

  twi_tick_gen #(.STD_Q(STD_Q), .FAST_Q(FAST_Q)) u_tick (
    .clk(clk), .rst_n(rst_n), .fast(fast_mode), .restart(start_req), .tick(tick)
  );

  always_comb begin
    sh_load  = tick && (((st == ST_START) && (qtr == 2'd3)) ||
               ((st == ST_BIT) && (qtr == 2'd3) && (bitc == ACK_SLOT) &&
                (seg == SEG_ADDR) && !nack_q && !rd_phase));
    sh_val   = (st == ST_START) ? twi_addr_byte(addr_q, rd_phase) : wdata_q;
    sh_shift = tick && (st == ST_BIT) && (qtr == 2'd1) && (bitc != ACK_SLOT);
  end

  twi_shifter #(.W(TWI_BYTE_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .par_in(sh_val),
    .shift(sh_shift), .ser_in(sda_i), .q(sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; seg <= SEG_ADDR; qtr <= 2'd0; bitc <= 4'd0;
      rd_phase <= 1'b0; combo_q <= 1'b0; retry_q <= 1'b0; nack_q <= 1'b0;
      scl_q <= 1'b1; low_q <= 1'b0; busy_q <= 1'b0; done_q <= 1'b0; err_q <= 1'b0;
      addr_q <= '0; wdata_q <= '0; rdata_q <= '0; tries_q <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        ST_IDLE: if (cmd_go) begin
          addr_q <= cmd_addr; wdata_q <= cmd_wdata; combo_q <= cmd_combo;
          retry_q <= cmd_nack_retry; rd_phase <= cmd_rd & ~cmd_combo;
          tries_q <= '0; err_q <= 1'b0; busy_q <= 1'b1;
          st <= ST_START; qtr <= 2'd2;
        end
        ST_START: if (tick) begin
          qtr <= qtr + 2'd1;
          case (qtr)
            2'd0: low_q <= 1'b0;
            2'd1: scl_q <= 1'b1;
            2'd2: low_q <= 1'b1;
            default: begin scl_q <= 1'b0; st <= ST_BIT; seg <= SEG_ADDR; bitc <= 4'd0; end
          endcase
        end
        ST_BIT: if (tick) begin
          qtr <= qtr + 2'd1;
          case (qtr)
            2'd0: low_q <= (bitc != ACK_SLOT) && (seg != SEG_RDATA) && !sh_q[TWI_BYTE_W-1];
            2'd1: begin scl_q <= 1'b1; if (bitc == ACK_SLOT) nack_q <= sda_i; end
            2'd2: ;
            default: begin
              scl_q <= 1'b0;
              if (bitc != ACK_SLOT) bitc <= bitc + 4'd1;
              else begin
                bitc <= 4'd0;
                case (seg)
                  SEG_ADDR:
                    if (nack_q) begin
                      err_q <= 1'b1;
                      if (retry_q && (tries_q < RETRY_MAX)) begin
                        tries_q <= tries_q + 1'b1; st <= ST_START;
                      end else st <= ST_STOP;
                    end else seg <= rd_phase ? SEG_RDATA : SEG_WDATA;
                  SEG_WDATA:
                    if (nack_q) begin err_q <= 1'b1; st <= ST_STOP; end
                    else if (combo_q) begin rd_phase <= 1'b1; st <= ST_START; end
                    else st <= ST_STOP;
                  default: begin rdata_q <= sh_q; st <= ST_STOP; end
                endcase
              end
            end
          endcase
        end
        default: if (tick) begin
          qtr <= qtr + 2'd1;
          case (qtr)
            2'd0: low_q <= 1'b1;
            2'd1: scl_q <= 1'b1;
            2'd2: low_q <= 1'b0;
            default: begin st <= ST_IDLE; busy_q <= 1'b0; done_q <= 1'b1; end
          endcase
        end
      endcase
    end
  end

  assign scl_o   = scl_q;
  assign sda_oe  = low_q;
  assign rd_data = rdata_q;
  assign done    = done_q;
  assign busy    = busy_q;
  assign ack_err = err_q;
endmodule

// File: rtl/twi_host_chk.sv
module twi_host_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic in_start,
  input logic in_stop,
  input logic scl_o,
  input logic sda_oe,
  input logic busy,
  input logic done,
  input logic ack_err,
  input logic cmd_go
);
  // R1
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (scl_o && !sda_oe));
  // R2
  a_r2_fall_only_start: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $rose(sda_oe)) |-> in_start);
  a_r2_rise_only_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $fell(sda_oe)) |-> in_stop);
  // R5
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r5_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R10
  a_r10_err_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_go && !busy) |=> !ack_err);
  // R11
  a_r11_scl_on_quarter: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(scl_o) |-> $past(tick));
endmodule

bind twi_host twi_host_chk u_twi_host_chk (
  .clk(clk), .rst_n(rst_n), .tick(ev_tick), .in_start(ev_in_start),
  .in_stop(ev_in_stop), .scl_o(scl_o), .sda_oe(sda_oe), .busy(busy),
  .done(done), .ack_err(ack_err), .cmd_go(cmd_go)
);

// File: tb/test_twi_host.sv
`timescale 1ns/1ps
module test_twi_host;
  localparam int unsigned SYS_HZ  = 4_000_000;
  localparam int unsigned RETRIES = 2;
  localparam logic [6:0] SLV_ADDR = 7'h52;
  localparam int STD_PERIOD  = 4 * (SYS_HZ / (4 * 100_000));
  localparam int FAST_PERIOD = 4 * (SYS_HZ / (4 * 400_000));

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_go = 1'b0, cmd_rd = 1'b0, cmd_combo = 1'b0, cmd_nack_retry = 1'b0, fast_mode = 1'b0;
  logic [6:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic scl_o, sda_oe, done, busy, ack_err;
  logic [7:0] rd_data;
  logic slv_pull = 1'b0;
  logic sda_bus;
  logic slv_ack_addr = 1'b1, slv_ack_data = 1'b1;
  logic [7:0] slv_rdata = 8'h00;

  int checks = 0, fails = 0;
  int exp_q[$];
  string tag_q[$];

  assign sda_bus = ~(sda_oe | slv_pull);

  always #5 clk = ~clk;

  twi_host #(.SYS_CLK_HZ(SYS_HZ), .RETRIES(RETRIES)) i_twi_host (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_addr(cmd_addr), .cmd_rd(cmd_rd),
    .cmd_wdata(cmd_wdata), .cmd_combo(cmd_combo), .cmd_nack_retry(cmd_nack_retry),
    .fast_mode(fast_mode), .sda_i(sda_bus), .scl_o(scl_o), .sda_oe(sda_oe),
    .rd_data(rd_data), .done(done), .busy(busy), .ack_err(ack_err)
  );

  task automatic check_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Expected bus tokens: -1 START, -2 STOP, else byte*2 + ack level.
  task automatic push(input int tok, input string tag);
    exp_q.push_back(tok);
    tag_q.push_back(tag);
  endtask

  function automatic int tok8(input logic [7:0] b, input logic ackbit);
    return int'(b) * 2 + int'(ackbit);
  endfunction

  task automatic observe(input int tok);
    string t;
    int e;
    if (exp_q.size() == 0) begin
      checks++; fails++;
      $display("FAIL R2/R3: actual %0d expected none (unexpected bus event)", tok);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check_eq(t, tok, e);
    end
  endtask

  // Monitor and target model in one process.
  initial begin : monitor
    logic prev_scl, prev_sda, in_frame, addressed, rd_mode;
    logic [8:0] sh;
    int bitn, byten;
    prev_scl = 1'b1; prev_sda = 1'b1; in_frame = 1'b0; addressed = 1'b0; rd_mode = 1'b0;
    sh = '0; bitn = 0; byten = 0;
    forever begin
      @(scl_o or sda_bus);
      if (rst_n) begin
        if (scl_o === 1'b1 && prev_scl === 1'b1 && sda_bus !== prev_sda) begin
          if (sda_bus === 1'b0) begin
            observe(-1);
            in_frame = 1'b1; bitn = 0; byten = 0; addressed = 1'b0; sh = '0;
          end else begin
            observe(-2);
            in_frame = 1'b0;
          end
        end else if (scl_o === 1'b1 && prev_scl === 1'b0 && in_frame) begin
          sh = {sh[7:0], sda_bus};
          bitn++;
          if (bitn == 9) begin
            observe(int'(sh));
            if (byten == 0) begin
              addressed = (sh[0] == 1'b0);
              rd_mode = sh[1];
            end else if (rd_mode && sh[0]) addressed = 1'b0;
            bitn = 0;
            byten++;
          end
        end else if (scl_o === 1'b0 && prev_scl === 1'b1) begin
          if (!in_frame) slv_pull = 1'b0;
          else if (byten == 0) slv_pull = (bitn == 8) && (sh[7:1] == SLV_ADDR) && slv_ack_addr;
          else if (addressed && !rd_mode) slv_pull = (bitn == 8) && slv_ack_data;
          else if (addressed && rd_mode) slv_pull = (bitn < 8) ? ~slv_rdata[7-bitn] : 1'b0;
          else slv_pull = 1'b0;
        end
      end
      prev_scl = scl_o;
      prev_sda = sda_bus;
    end
  end

  task automatic measure(input int exp_period, input string tag);
    time t0, t1;
    @(posedge scl_o); t0 = $time;
    @(posedge scl_o); t1 = $time;
    check_eq(tag, int'((t1 - t0) / 10), exp_period);
  endtask

  task automatic wait_done(output bit got);
    got = 1'b0;
    for (int i = 0; i < 40000; i++) begin
      @(negedge clk);
      if (done) begin got = 1'b1; break; end
    end
  endtask

  task automatic run_tx(input logic [6:0] a, input logic rd, input logic combo,
                        input logic retry, input logic fast, input logic [7:0] wd,
                        input string tag, input string err_tag);
    logic dir, anack, dnack, exp_err, exp_rd_valid;
    int tries;
    bit got;
    dir = rd & ~combo;
    exp_err = 1'b0; exp_rd_valid = 1'b0;
    anack = !((a == SLV_ADDR) && slv_ack_addr);
    tries = (anack && retry) ? int'(RETRIES) + 1 : 1;
    for (int k = 0; k < tries; k++) begin
      push(-1, tag);
      push(tok8({a, dir}, anack), tag);
    end
    if (anack) begin
      push(-2, tag); exp_err = 1'b1;
    end else if (!dir) begin
      dnack = !slv_ack_data;
      push(tok8(wd, dnack), tag);
      if (dnack) begin push(-2, tag); exp_err = 1'b1; end
      else if (combo) begin
        push(-1, tag); push(tok8({a, 1'b1}, 1'b0), tag);
        push(tok8(slv_rdata, 1'b1), tag); push(-2, tag); exp_rd_valid = 1'b1;
      end else push(-2, tag);
    end else begin
      push(tok8(slv_rdata, 1'b1), tag); push(-2, tag); exp_rd_valid = 1'b1;
    end

    @(negedge clk);
    cmd_addr = a; cmd_rd = rd; cmd_combo = combo; cmd_nack_retry = retry;
    fast_mode = fast; cmd_wdata = wd; cmd_go = 1'b1;
    @(negedge clk);
    cmd_go = 1'b0;
    check_eq("R10 ack_err cleared at accept", int'(ack_err), 0);
    check_eq("R5 busy after accept", int'(busy), 1);
    fork
      measure(fast ? FAST_PERIOD : STD_PERIOD, "R11 SCL period");
      wait_done(got);
    join
    check_eq({tag, " done seen"}, int'(got), 1);
    check_eq({err_tag, " ack_err"}, int'(ack_err), int'(exp_err));
    check_eq("R5 busy low at done", int'(busy), 0);
    if (exp_rd_valid) check_eq({tag, " rd_data"}, int'(rd_data), int'(slv_rdata));
    @(negedge clk);
    check_eq("R5 done one cycle", int'(done), 0);
    check_eq("R1 scl released", int'(scl_o), 1);
    check_eq("R1 sda released", int'(sda_oe), 0);
    check_eq({tag, " all bus events seen"}, exp_q.size(), 0);
    exp_q.delete(); tag_q.delete();
    repeat (20) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin : main
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 reset scl", int'(scl_o), 1);
    check_eq("R1 reset sda_oe", int'(sda_oe), 0);
    check_eq("R1 reset busy", int'(busy), 0);
    check_eq("R1 reset ack_err", int'(ack_err), 0);

    // R3 R4 R5: plain write, standard rate
    slv_ack_addr = 1'b1; slv_ack_data = 1'b1; slv_rdata = 8'h3C;
    run_tx(SLV_ADDR, 1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, "R3/R5 write", "R5");
    // R6: read, fast rate, retry enabled but unused
    run_tx(SLV_ADDR, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R6 read", "R6");
    // R7: combined write then read
    slv_rdata = 8'hC3;
    run_tx(SLV_ADDR, 1'b0, 1'b1, 1'b0, 1'b0, 8'h0F, "R7 combined", "R7");
    // R8: wrong address, no retry
    run_tx(7'h13, 1'b0, 1'b0, 1'b0, 1'b1, 8'h55, "R8 addr NACK stop", "R8");
    // R9: refused address with retries
    slv_ack_addr = 1'b0;
    run_tx(SLV_ADDR, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, "R9 addr NACK retry", "R9");
    // R12: data byte refused
    slv_ack_addr = 1'b1; slv_ack_data = 1'b0;
    run_tx(SLV_ADDR, 1'b0, 1'b1, 1'b0, 1'b0, 8'h81, "R12 data NACK", "R12");
    // R10: clean write after an error clears the flag
    slv_ack_data = 1'b1;
    run_tx(SLV_ADDR, 1'b0, 1'b0, 1'b0, 1'b1, 8'h6E, "R10 recovery write", "R10");

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule